// File: doc/BRIEF.md
# Distributed Beam Partial-Sum Stage

This block is one link in a chain of identical stages that together form frequency-domain beams for a large sensor array. Each stage holds the already windowed and transformed spectra of its own sensor channels, and a table of complex steering phases. For every beam direction and every frequency bin it multiplies each local channel's complex bin by that channel's steering phase for the beam and bin. It sums these products over the local channels and adds the partial beam value that arrives from the stage before it. The total goes out to the next stage. The last stage in the chain therefore emits complete beams, and a larger array only needs more stages.

One complex multiplier is reused for every channel, beam and bin product in turn. Spectra and steering phases are loaded through simple write ports while the stage is idle. A one-cycle start pulse then runs a whole frame. Results leave beam by beam, with bins in ascending order, over a valid/ready stream. The upstream stream must use the same order, and the stage stalls it until the matching local sum exists. A stage set as the head of the chain ignores the upstream stream. The default parameters are small; a deployment typically sets 8 channels, 16 beams and 256 bins.

Top module: `beam_partial_stage`

## Requirements
- R1: After reset, dn_valid, up_ready and frame_done are all 0.
- R2: For beam m and bin k, the stage computes L = sum over channels c of X(c,k)*W(m,k,c). X is the stored spectrum and W the stored coefficient, both complex. The real part is xr*wr - xi*wi and the imaginary part is xr*wi + xi*wr. The output is L plus the upstream value U, with U scaled by 2^(CW-1), then rounded and saturated as in R8 and R9.
- R3: A coefficient for channel c, beam m and bin k is written at coef_addr = (m*NBIN + k)*NCH + c. A spectrum value for channel c and bin k is written at spec_addr = c*NBIN + k. In both words the real part is the upper half and the imaginary part is the lower half, as separate ports.
- R4: A frame emits exactly NBEAM*NBIN results in beam-major order, with bins ascending inside each beam. A frame_start pulse restarts the frame at beam 0, bin 0.
- R5: When cfg_first is 1, the upstream inputs have no effect: U is taken as zero and up_ready stays 0.
- R6: When cfg_first is 0, each output consumes exactly one upstream item, in order. No output is produced while up_valid is 0.
- R7: While dn_valid is 1 and dn_ready is 0, dn_valid stays 1 and dn_re and dn_im do not change.
- R8: Rounding divides by 2^(CW-1) and rounds exact halves toward positive infinity, so +0.5 becomes 1 and -0.5 becomes 0.
- R9: A rounded result outside the OW-bit signed range is clamped to 2^(OW-1)-1 or -2^(OW-1).
- R10: frame_done goes to 1 in the cycle after the last result of a frame is accepted downstream. A frame_start pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first | input | 1 | Stage is head of chain; upstream treated as zero |
| coef_we | input | 1 | Coefficient table write strobe |
| coef_addr | input | CAW | Coefficient table address |
| coef_re | input | CW | Coefficient real part, signed Q1.(CW-1) |
| coef_im | input | CW | Coefficient imaginary part, signed Q1.(CW-1) |
| spec_we | input | 1 | Spectrum buffer write strobe |
| spec_addr | input | SAW | Spectrum buffer address |
| spec_re | input | DW | Spectrum real part, signed |
| spec_im | input | DW | Spectrum imaginary part, signed |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| up_valid | input | 1 | Upstream partial sum valid |
| up_ready | output | 1 | Upstream partial sum accepted |
| up_re | input | OW | Upstream partial sum real part |
| up_im | input | OW | Upstream partial sum imaginary part |
| dn_valid | output | 1 | Downstream result valid |
| dn_ready | input | 1 | Downstream consumer ready |
| dn_re | output | OW | Result real part |
| dn_im | output | OW | Result imaginary part |
| frame_done | output | 1 | Last result of the frame has been accepted |

## Verification
The assertions rely on three properties of the inputs. frame_start arrives only while no frame is running. Table and buffer writes happen only between frames. The upstream stream keeps its data steady until it is accepted. The stimulus respects all three: it loads memories before each pulse, pulses start only after frame_done, and the upstream driver changes its word only after a handshake. Within those limits, the bench inserts gaps in up_valid and drops dn_ready to exercise stalls from both sides.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_t;

  // index width that stays legal for a count of one
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bps_ram.sv
`timescale 1ns/1ps
module bps_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  parameter int ABITS = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ABITS-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [ABITS-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bps_seq.sv
`timescale 1ns/1ps
module bps_seq import bps_pkg::*; #(
  parameter int NCH   = 4,
  parameter int NBEAM = 4,
  parameter int NBIN  = 64,
  localparam int CHW  = bits_for(NCH),
  localparam int BNW  = bits_for(NBIN),
  localparam int BMW  = bits_for(NBEAM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic           xfer,
  output logic           rd_en,
  output logic [CHW-1:0] ch,
  output logic [BNW-1:0] bin,
  output logic [BMW-1:0] beam,
  output logic           first_tag,
  output logic           last_tag,
  output logic           frame_last
);
  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      ch   <= '0;
      bin  <= '0;
      beam <= '0;
    end else if (frame_start) begin
      st   <= SQ_ISSUE;
      ch   <= '0;
      bin  <= '0;
      beam <= '0;
    end else begin
      case (st)
        SQ_ISSUE: begin
          if (ch == CHW'(NCH - 1)) begin
            ch <= '0;
            st <= SQ_WAIT;
          end else begin
            ch <= ch + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (xfer) begin
            if (frame_last) begin
              st <= SQ_IDLE;
            end else begin
              st <= SQ_ISSUE;
              if (bin == BNW'(NBIN - 1)) begin
                bin  <= '0;
                beam <= beam + 1'b1;
              end else begin
                bin <= bin + 1'b1;
              end
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en      = (st == SQ_ISSUE);
    first_tag  = (ch == '0);
    last_tag   = (ch == CHW'(NCH - 1));
    frame_last = (beam == BMW'(NBEAM - 1)) && (bin == BNW'(NBIN - 1));
  end

  // R4
  // a result may only leave while its bin has been fully issued
  xfer_wait_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (st == SQ_WAIT))
    else $error("result transferred outside the wait state");
endmodule

// File: rtl/bps_cmac.sv
`timescale 1ns/1ps
module bps_cmac #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 42
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 clr,
  input  logic                 iss_v,
  input  logic                 iss_first,
  input  logic                 iss_last,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [CW-1:0] c_re,
  input  logic signed [CW-1:0] c_im,
  output logic signed [AW-1:0] acc_re,
  output logic signed [AW-1:0] acc_im,
  output logic                 acc_done
);
  localparam int MW = DW + CW;
  localparam int PW = MW + 1;

  logic v1, f1, l1, v2, f2, l2;
  logic signed [MW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [PW-1:0] s_re, s_im;

  // stage 1: tags follow the registered memory read
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v1 <= 1'b0;
      f1 <= 1'b0;
      l1 <= 1'b0;
    end else begin
      v1 <= iss_v;
      f1 <= iss_first;
      l1 <= iss_last;
    end
  end

  // stage 2: the four partial products of one complex multiply
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v2 <= 1'b0;
      f2 <= 1'b0;
      l2 <= 1'b0;
    end else begin
      v2 <= v1;
      f2 <= f1;
      l2 <= l1;
    end
    if (v1) begin
      p_rr <= x_re * c_re;
      p_ii <= x_im * c_im;
      p_ri <= x_re * c_im;
      p_ir <= x_im * c_re;
    end
  end

  always_comb begin
    s_re = PW'(p_rr) - PW'(p_ii);
    s_im = PW'(p_ri) + PW'(p_ir);
  end

  // stage 3: accumulate across channels
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_re   <= '0;
      acc_im   <= '0;
      acc_done <= 1'b0;
    end else begin
      if (v2) begin
        acc_re <= (f2 ? '0 : acc_re) + AW'(s_re);
        acc_im <= (f2 ? '0 : acc_im) + AW'(s_im);
      end
      if (flush || clr)   acc_done <= 1'b0;
      else if (v2 && l2)  acc_done <= 1'b1;
    end
  end

  // R2
  // a finished sum is never disturbed by a further product
  prod_order_chk: assert property (@(posedge clk) disable iff (rst)
    v2 |-> !acc_done)
    else $error("product arrived on a completed sum");
endmodule

// File: rtl/bps_merge.sv
`timescale 1ns/1ps
module bps_merge #(
  parameter int AW = 42,
  parameter int CW = 16,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_first,
  input  logic                 frame_start,
  input  logic                 frame_last,
  input  logic signed [AW-1:0] acc_re,
  input  logic signed [AW-1:0] acc_im,
  input  logic                 acc_done,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic signed [OW-1:0] up_re,
  input  logic signed [OW-1:0] up_im,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic signed [OW-1:0] dn_re,
  output logic signed [OW-1:0] dn_im,
  output logic                 frame_done,
  output logic                 xfer
);
  localparam int SW = AW + 1;
  localparam int SH = CW - 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SH - 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  function automatic logic signed [OW-1:0] rnd_sat(input logic signed [SW-1:0] t);
    logic signed [SW-1:0] s;
    s = (t + HALF) >>> SH;
    if (s > MAXV)      return MAXV[OW-1:0];
    else if (s < MINV) return MINV[OW-1:0];
    else               return s[OW-1:0];
  endfunction

  logic                 out_free, out_last;
  logic signed [SW-1:0] u_re, u_im, t_re, t_im;

  always_comb begin
    out_free = !dn_valid || dn_ready;
    xfer     = acc_done && out_free && (cfg_first || up_valid);
    up_ready = acc_done && out_free && !cfg_first;
    u_re     = cfg_first ? '0 : (SW'(up_re) <<< SH);
    u_im     = cfg_first ? '0 : (SW'(up_im) <<< SH);
    t_re     = SW'(acc_re) + u_re;
    t_im     = SW'(acc_im) + u_im;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid   <= 1'b0;
      dn_re      <= '0;
      dn_im      <= '0;
      out_last   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      if (xfer) begin
        dn_valid <= 1'b1;
        dn_re    <= rnd_sat(t_re);
        dn_im    <= rnd_sat(t_im);
        out_last <= frame_last;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
      if (frame_start)                        frame_done <= 1'b0;
      else if (dn_valid && dn_ready && out_last) frame_done <= 1'b1;
    end
  end

  // R7
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_re) && $stable(dn_im))
    else $error("downstream word changed under backpressure");

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_done)
    else $error("frame_done survived a frame start");

  // R6
  rose_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_valid) |-> $past(cfg_first || up_valid))
    else $error("result emitted without upstream data");
endmodule

// File: rtl/beam_partial_stage.sv
`timescale 1ns/1ps
module beam_partial_stage import bps_pkg::*; #(
  parameter int NCH   = 4,
  parameter int NBEAM = 4,
  parameter int NBIN  = 64,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 24,
  localparam int CAW  = bits_for(NCH * NBEAM * NBIN),
  localparam int SAW  = bits_for(NCH * NBIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_first,
  input  logic                 coef_we,
  input  logic [CAW-1:0]       coef_addr,
  input  logic signed [CW-1:0] coef_re,
  input  logic signed [CW-1:0] coef_im,
  input  logic                 spec_we,
  input  logic [SAW-1:0]       spec_addr,
  input  logic signed [DW-1:0] spec_re,
  input  logic signed [DW-1:0] spec_im,
  input  logic                 frame_start,
  input  logic                 up_valid,
  output logic                 up_ready,
  input  logic signed [OW-1:0] up_re,
  input  logic signed [OW-1:0] up_im,
  output logic                 dn_valid,
  input  logic                 dn_ready,
  output logic signed [OW-1:0] dn_re,
  output logic signed [OW-1:0] dn_im,
  output logic                 frame_done
);
  localparam int CHW   = bits_for(NCH);
  localparam int BNW   = bits_for(NBIN);
  localparam int BMW   = bits_for(NBEAM);
  localparam int NEED  = (OW + CW > DW + CW + CHW + 1) ? (OW + CW) : (DW + CW + CHW + 1);
  localparam int AW    = NEED + 2;
  localparam int CDEP  = NCH * NBEAM * NBIN;
  localparam int SDEP  = NCH * NBIN;

  logic                 rd_en, first_tag, last_tag, frame_last, acc_done, xfer;
  logic [CHW-1:0]       ch;
  logic [BNW-1:0]       bin;
  logic [BMW-1:0]       beam;
  logic [CAW-1:0]       c_raddr;
  logic [SAW-1:0]       s_raddr;
  logic [2*CW-1:0]      c_word;
  logic [2*DW-1:0]      s_word;
  logic signed [CW-1:0] w_re, w_im;
  logic signed [DW-1:0] x_re, x_im;
  logic signed [AW-1:0] acc_re, acc_im;

  bps_seq #(.NCH(NCH), .NBEAM(NBEAM), .NBIN(NBIN)) u_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start), .xfer(xfer),
    .rd_en(rd_en), .ch(ch), .bin(bin), .beam(beam),
    .first_tag(first_tag), .last_tag(last_tag), .frame_last(frame_last)
  );

  always_comb begin
    c_raddr = CAW'((int'(beam) * NBIN + int'(bin)) * NCH + int'(ch));
    s_raddr = SAW'(int'(ch) * NBIN + int'(bin));
    w_re    = c_word[2*CW-1:CW];
    w_im    = c_word[CW-1:0];
    x_re    = s_word[2*DW-1:DW];
    x_im    = s_word[DW-1:0];
  end

  bps_ram #(.W(2*CW), .DEPTH(CDEP), .ABITS(CAW)) u_coef (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata({coef_re, coef_im}),
    .re(rd_en), .raddr(c_raddr), .rdata(c_word)
  );

  bps_ram #(.W(2*DW), .DEPTH(SDEP), .ABITS(SAW)) u_spec (
    .clk(clk), .we(spec_we), .waddr(spec_addr), .wdata({spec_re, spec_im}),
    .re(rd_en), .raddr(s_raddr), .rdata(s_word)
  );

  bps_cmac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .clk(clk), .rst(rst), .flush(frame_start), .clr(xfer),
    .iss_v(rd_en), .iss_first(first_tag), .iss_last(last_tag),
    .x_re(x_re), .x_im(x_im), .c_re(w_re), .c_im(w_im),
    .acc_re(acc_re), .acc_im(acc_im), .acc_done(acc_done)
  );

  bps_merge #(.AW(AW), .CW(CW), .OW(OW)) u_merge (
    .clk(clk), .rst(rst), .cfg_first(cfg_first), .frame_start(frame_start),
    .frame_last(frame_last), .acc_re(acc_re), .acc_im(acc_im), .acc_done(acc_done),
    .up_valid(up_valid), .up_ready(up_ready), .up_re(up_re), .up_im(up_im),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_re(dn_re), .dn_im(dn_im),
    .frame_done(frame_done), .xfer(xfer)
  );

  // R2
  // the sequencer never reissues while a finished sum waits to leave
  issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !acc_done)
    else $error("issue overlapped a pending sum");
endmodule

// File: tb/beam_partial_stage_test.sv
`timescale 1ns/1ps
module beam_partial_stage_test;
  localparam int NCH = 2, NBEAM = 2, NBIN = 4, DW = 16, CW = 16, OW = 24;
  localparam int TOT = NBEAM * NBIN;
  localparam int CAW = 4, SAW = 3;

  logic clk = 1'b0, rst = 1'b1, cfg_first = 1'b1;
  logic coef_we = 1'b0, spec_we = 1'b0, frame_start = 1'b0;
  logic [CAW-1:0] coef_addr = '0;
  logic [SAW-1:0] spec_addr = '0;
  logic signed [CW-1:0] coef_re = '0, coef_im = '0;
  logic signed [DW-1:0] spec_re = '0, spec_im = '0;
  logic up_valid = 1'b0, dn_ready = 1'b0;
  logic signed [OW-1:0] up_re = '0, up_im = '0;
  logic up_ready, dn_valid, frame_done;
  logic signed [OW-1:0] dn_re, dn_im;

  always #4 clk = ~clk;

  beam_partial_stage #(.NCH(NCH), .NBEAM(NBEAM), .NBIN(NBIN), .DW(DW), .CW(CW), .OW(OW)) uut (
    .clk(clk), .rst(rst), .cfg_first(cfg_first),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_re(coef_re), .coef_im(coef_im),
    .spec_we(spec_we), .spec_addr(spec_addr), .spec_re(spec_re), .spec_im(spec_im),
    .frame_start(frame_start), .up_valid(up_valid), .up_ready(up_ready),
    .up_re(up_re), .up_im(up_im), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_re(dn_re), .dn_im(dn_im), .frame_done(frame_done)
  );

  int checks = 0, errors = 0;
  int unsigned seed = 32'h1234_5678;
  int sre [NCH][NBIN], sim [NCH][NBIN];
  int cre [NBEAM][NBIN][NCH], cim [NBEAM][NBIN][NCH];
  int ure [TOT], uim [TOT];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[31:16]) - 32768;
  endfunction

  function automatic longint rsat(input longint t);
    longint s;
    s = (t + 16384) >>> 15;
    if (s > 8388607)  s = 8388607;
    if (s < -8388608) s = -8388608;
    return s;
  endfunction

  function automatic longint exp_val(input int k, input bit first, input bit imag);
    int m = k / NBIN, b = k % NBIN;
    longint sr = 0, si = 0, u;
    for (int c = 0; c < NCH; c++) begin
      sr += longint'(sre[c][b]) * cre[m][b][c] - longint'(sim[c][b]) * cim[m][b][c];
      si += longint'(sre[c][b]) * cim[m][b][c] + longint'(sim[c][b]) * cre[m][b][c];
    end
    u = first ? 0 : (imag ? uim[k] : ure[k]);
    return rsat((imag ? si : sr) + u * 32768);
  endfunction

  // mode 0 random, 1 exact halves, 2 saturation
  task automatic fill(input int mode);
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NBIN; b++) begin
        case (mode)
          1: begin sre[c][b] = (c == 0) ? 1 : 0; sim[c][b] = 0; end
          2: begin sre[c][b] = 32767; sim[c][b] = -32768; end
          default: begin sre[c][b] = rnd16(); sim[c][b] = rnd16(); end
        endcase
      end
    for (int m = 0; m < NBEAM; m++)
      for (int b = 0; b < NBIN; b++)
        for (int c = 0; c < NCH; c++) begin
          case (mode)
            1: begin cre[m][b][c] = (m == 0) ? 16384 : -16384; cim[m][b][c] = (b % 2) ? 16384 : 0; end
            2: begin cre[m][b][c] = (m == 0) ? 32767 : -32768; cim[m][b][c] = (m == 0) ? 32767 : -32768; end
            default: begin cre[m][b][c] = rnd16(); cim[m][b][c] = rnd16(); end
          endcase
        end
    for (int k = 0; k < TOT; k++) begin
      case (mode)
        1: begin ure[k] = 0; uim[k] = 0; end
        2: begin ure[k] = (k < NBIN) ? 8388000 : -8388000; uim[k] = (k < NBIN) ? -8388000 : 8388000; end
        default: begin ure[k] = rnd16() * 128; uim[k] = rnd16() * 128; end
      endcase
    end
  endtask

  // R3: address layout of both write ports
  task automatic load_all();
    for (int m = 0; m < NBEAM; m++)
      for (int b = 0; b < NBIN; b++)
        for (int c = 0; c < NCH; c++) begin
          @(negedge clk);
          coef_we   = 1'b1;
          coef_addr = CAW'((m * NBIN + b) * NCH + c);
          coef_re   = CW'(cre[m][b][c]);
          coef_im   = CW'(cim[m][b][c]);
        end
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NBIN; b++) begin
        @(negedge clk);
        coef_we   = 1'b0;
        spec_we   = 1'b1;
        spec_addr = SAW'(c * NBIN + b);
        spec_re   = DW'(sre[c][b]);
        spec_im   = DW'(sim[c][b]);
      end
    @(negedge clk);
    spec_we = 1'b0;
  endtask

  task automatic run_frame(input bit first, input bit bp, input bit gap, input string tag);
    int out_n = 0, up_n = 0, upr_seen = 0, cyc = 0, early_done = 0;
    bit hold = 0, done_seen = 0;
    longint h_re = 0, h_im = 0;
    @(negedge clk);
    cfg_first   = first;
    frame_start = 1'b1;
    while (!done_seen) begin
      @(negedge clk);
      cyc++;
      frame_start = 1'b0;
      if (cyc == 1) check(frame_done == 1'b0, "R10 cleared by start", frame_done, 0);
      if (hold) begin
        check(dn_valid && longint'(dn_re) == h_re && longint'(dn_im) == h_im,
              "R7 held under backpressure", longint'(dn_re), h_re);
        hold = 0;
      end
      dn_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      if (first) begin
        up_valid = 1'b1;
        up_re = 24'sh5A5A5A;
        up_im = -24'sh123456;
      end else begin
        up_valid = (up_n < TOT) && (!gap || (cyc % 4) != 1);
        up_re = (up_n < TOT) ? OW'(ure[up_n]) : '0;
        up_im = (up_n < TOT) ? OW'(uim[up_n]) : '0;
      end
      #1;
      if (frame_done) begin
        done_seen = 1;
        check(out_n == TOT, "R10 done after last result", out_n, TOT);
      end
      if (up_ready) upr_seen++;
      if (up_valid && up_ready) up_n++;
      if (dn_valid && !dn_ready) begin
        hold = 1;
        h_re = longint'(dn_re);
        h_im = longint'(dn_im);
      end
      if (dn_valid && dn_ready && !done_seen) begin
        if (out_n < TOT) begin
          longint er = exp_val(out_n, first, 1'b0);
          longint ei = exp_val(out_n, first, 1'b1);
          check(longint'(dn_re) == er, {"R2 R4 real ", tag}, longint'(dn_re), er);
          check(longint'(dn_im) == ei, {"R2 R4 imag ", tag}, longint'(dn_im), ei);
        end
        out_n++;
        if (out_n < TOT && frame_done) early_done++;
      end
      if (cyc > 3000) begin
        check(1'b0, {"R4 watchdog ", tag}, out_n, TOT);
        done_seen = 1;
      end
    end
    check(early_done == 0, "R10 no early done", early_done, 0);
    if (first) check(upr_seen == 0, "R5 up_ready stays low", upr_seen, 0);
    else       check(up_n == TOT, "R6 one upstream item per result", up_n, TOT);
    dn_ready = 1'b0;
    up_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dn_valid == 1'b0, "R1 dn_valid", dn_valid, 0);
    check(up_ready == 1'b0, "R1 up_ready", up_ready, 0);
    check(frame_done == 1'b0, "R1 frame_done", frame_done, 0);

    fill(0); load_all(); run_frame(1'b1, 1'b0, 1'b0, "R5 head stage");
    fill(0); load_all(); run_frame(1'b0, 1'b1, 1'b1, "R6 stalls both sides");
    fill(1); load_all(); run_frame(1'b1, 1'b1, 1'b0, "R8 exact halves");
    fill(2); load_all(); run_frame(1'b0, 1'b0, 1'b1, "R9 saturation");
    fill(0); load_all(); run_frame(1'b0, 1'b0, 1'b0, "R4 full rate");
    run_frame(1'b0, 1'b1, 1'b0, "R4 restart same tables");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule